// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache with Early Restart

This block is a direct-mapped cache between a processor port and a backing memory that moves one 32-bit word per transaction. Each of the 64 lines holds four words, a valid bit and a tag. A read that misses holds the processor stalled and refills the line. The missing word is fetched first. The stall drops in the cycle that word returns, and the other three words keep arriving in the background.

Stores never allocate. A store that hits updates the cached word. Every store, hit or miss, goes into a four-entry posted write buffer, which drains to memory when the port is free. The processor stalls on a store only while the buffer is full.

The memory port carries one transaction at a time. Refill reads take precedence over buffered writes. A read miss whose block still has a store waiting in the buffer holds off its refill until that store has been written.

The miss handler has four states:
- **IDLE**: serves hits and stores. A read miss goes to DRAIN when the buffer holds a store to the same block, and to FIRST otherwise.
- **DRAIN**: waits until no buffered store matches the block, then goes to FIRST.
- **FIRST**: fetches the requested word. When that word returns it goes to REST and releases the processor.
- **REST**: fetches the remaining words, in order. When the last word returns it sets the tag and valid bit and goes back to IDLE.

Top module: `wt_dm_cache`

## Requirements
- R1: A byte address splits into tag = addr[31:10], line index = addr[9:4] and word = addr[3:2]. A hit needs the line's valid bit set and its stored tag equal to the tag of the address. Two addresses with the same index and different tags evict each other.
- R2: After reset every line is invalid. The first read to any address therefore misses.
- R3: A read hit completes in the cycle it is presented, with no stall, and returns the stored word.
- R4: A read miss stalls the processor. It issues four word reads for the line. The first is the requested word, and the rest follow in ascending order, wrapping modulo 4.
- R5: On a read miss the stall is released in the cycle the requested word's memory acknowledge arrives, with that word on cpu_rdata, before any other word of the line has returned.
- R6: Once a refill completes, all four words of the line hit.
- R7: Every accepted store produces exactly one memory write with its address and data, in acceptance order. A store that hits also updates the cached word.
- R8: A store miss does not allocate. A later read of that address misses and returns the stored data from memory.
- R9: The write buffer holds four stores. A store is accepted without stalling while fewer than four are pending, and it stalls when four are pending.
- R10: A read miss to a block that has a buffered store does not issue its refill reads until that store has been written. The refill returns the stored data.
- R11: The memory port carries one transaction at a time. Its request, address and direction stay stable until the acknowledge. When a refill read and a buffered write are both waiting, the refill read is issued first.
- R12: While the rest of a line streams in, accesses to other lines proceed (read hits and stores with room in the buffer). Any access to the line being refilled stalls until the refill ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the accepting cycle |
| cpu_stall | output | 1 | Access not accepted this cycle |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The properties assume a processor that holds cpu_req, cpu_we, cpu_addr and cpu_wdata unchanged while cpu_stall is high. They also assume a memory that raises mem_ack for one cycle and only while mem_req is high. The check on the critical word relies on the held address, because it compares the first refill read against cpu_addr. The stimulus drives every access through one task that keeps the request steady until it is accepted. A latency-counting memory model answers only an open request and drops the acknowledge the next cycle, so both assumptions hold throughout the run.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FIRST = 2'd2,
        ST_REST  = 2'd3
    } fill_state_t;

endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 22,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = $clog2(LINES),
    localparam int WORD_W    = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WORD_W-1:0] lk_word,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              fw_en,
    input  logic [IDX_W-1:0]  fw_idx,
    input  logic [WORD_W-1:0] fw_word,
    input  logic [DATA_W-1:0] fw_data,
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WORD_W-1:0] sw_word,
    input  logic [DATA_W-1:0] sw_data
);

    logic              valid_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [DATA_W-1:0] data_q  [LINES][LINE_WORDS];

    assign lk_valid = valid_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_data  = data_q[lk_idx][lk_word];

    // valid bits are the only state that must be known after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) valid_q[i] <= 1'b0;
        end else begin
            if (inv_en) valid_q[inv_idx] <= 1'b0;
            if (set_en) valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    // refill and store-hit writes never target the same line in one cycle
    always_ff @(posedge clk) begin
        if (fw_en) data_q[fw_idx][fw_word] <= fw_data;
        if (sw_en) data_q[sw_idx][sw_word] <= sw_data;
    end

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BLK_LSB = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1,
    localparam int BLK_W  = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    input  logic [BLK_W-1:0]  q_blk,
    output logic              q_match
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  hit_v;

    assign full      = (count_q == CNT_W'(DEPTH));
    assign empty     = (count_q == '0);
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];

    // per-entry block compare, limited to occupied slots
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [PTR_W-1:0] rel;
        assign rel      = PTR_W'(g) - head_q;
        assign hit_v[g] = ({1'b0, rel} < count_q) &&
                          (addr_q[g][ADDR_W-1:BLK_LSB] == q_blk);
    end
    assign q_match = |hit_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail_q] <= push_addr;
            data_q[tail_q] <= push_data;
        end
    end

endmodule

// File: rtl/wtc_mem_arb.sv
module wtc_mem_arb #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_want,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              wb_empty,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              fill_ack,
    output logic              wb_pop
);

    logic              active_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign mem_req   = active_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
    assign fill_ack  = active_q && mem_ack && !we_q;
    assign wb_pop    = active_q && mem_ack && we_q;

    // one transaction in flight; refill reads win over buffered writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else if (active_q) begin
            if (mem_ack) active_q <= 1'b0;
        end else if (fill_want) begin
            active_q <= 1'b1;
            we_q     <= 1'b0;
            addr_q   <= fill_addr;
        end else if (!wb_empty) begin
            active_q <= 1'b1;
            we_q     <= 1'b1;
            addr_q   <= wb_addr;
            data_q   <= wb_data;
        end
    end

endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 64,
    parameter int WB_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int WORD_W   = $clog2(LINE_WORDS);
    localparam int IDX_W    = $clog2(LINES);
    localparam int OFF_W    = BYTE_OFF + WORD_W;
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W    = ADDR_W - OFF_W;

    // address fields of the presented access
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WORD_W-1:0] req_word;
    logic [BLK_W-1:0]  req_blk;
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_addr[OFF_W +: IDX_W];
    assign req_word = cpu_addr[BYTE_OFF +: WORD_W];
    assign req_blk  = cpu_addr[ADDR_W-1:OFF_W];

    fill_state_t       state_q, state_d;
    logic [TAG_W-1:0]  fill_tag_q;
    logic [IDX_W-1:0]  fill_idx_q;
    logic [WORD_W-1:0] crit_q;
    logic [WORD_W-1:0] cnt_q;
    logic [WORD_W-1:0] fill_word;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_last;

    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              hit;
    logic              miss_start, store_go;
    logic              wb_full, wb_empty, blk_match, wb_pop;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;
    logic              fill_want, fill_ack;

    assign hit       = lk_valid && (lk_tag == req_tag);
    assign fill_word = crit_q + cnt_q;
    assign fill_addr = {fill_tag_q, fill_idx_q, fill_word, {BYTE_OFF{1'b0}}};
    assign fill_last = (cnt_q == WORD_W'(LINE_WORDS - 1));
    assign fill_want = (state_q == ST_FIRST) || (state_q == ST_REST);

    wtc_line_store #(
        .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_idx), .lk_word(req_word),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .inv_en(miss_start), .inv_idx(req_idx),
        .set_en(fill_ack && fill_last), .set_idx(fill_idx_q), .set_tag(fill_tag_q),
        .fw_en(fill_ack), .fw_idx(fill_idx_q), .fw_word(fill_word), .fw_data(mem_rdata),
        .sw_en(store_go && hit), .sw_idx(req_idx), .sw_word(req_word), .sw_data(cpu_wdata)
    );

    wtc_wbuf #(
        .DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LSB(OFF_W)
    ) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(store_go), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .pop(wb_pop), .head_addr(wb_addr), .head_data(wb_data),
        .full(wb_full), .empty(wb_empty),
        .q_blk(req_blk), .q_match(blk_match)
    );

    wtc_mem_arb #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n),
        .fill_want(fill_want), .fill_addr(fill_addr),
        .wb_empty(wb_empty), .wb_addr(wb_addr), .wb_data(wb_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .fill_ack(fill_ack), .wb_pop(wb_pop)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and processor-facing outputs
    always_comb begin
        state_d    = state_q;
        cpu_stall  = 1'b0;
        cpu_rdata  = lk_data;
        miss_start = 1'b0;
        store_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        cpu_stall = wb_full;
                        store_go  = !wb_full;
                    end else if (!hit) begin
                        cpu_stall  = 1'b1;
                        miss_start = 1'b1;
                        state_d    = blk_match ? ST_DRAIN : ST_FIRST;
                    end
                end
            end
            ST_DRAIN: begin
                cpu_stall = cpu_req;
                if (!blk_match) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                cpu_stall = cpu_req && !fill_ack;
                cpu_rdata = mem_rdata;
                if (fill_ack) state_d = ST_REST;
            end
            ST_REST: begin
                if (cpu_req) begin
                    if (req_idx == fill_idx_q) begin
                        cpu_stall = 1'b1;
                    end else if (cpu_we) begin
                        cpu_stall = wb_full;
                        store_go  = !wb_full;
                    end else begin
                        cpu_stall = !hit;
                    end
                end
                if (fill_ack && fill_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // refill bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_tag_q <= '0;
            fill_idx_q <= '0;
            crit_q     <= '0;
            cnt_q      <= '0;
        end else if (miss_start) begin
            fill_tag_q <= req_tag;
            fill_idx_q <= req_idx;
            crit_q     <= req_word;
            cnt_q      <= '0;
        end else if (fill_ack) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wt_dm_cache_chk.sv
module wt_dm_cache_chk
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 6,
    parameter int OFF_W    = 4,
    parameter int BYTE_OFF = 2,
    parameter int WORD_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input fill_state_t       state_q,
    input logic [IDX_W-1:0]  fill_idx_q,
    input logic              blk_match
);

    // memory request held steady until acknowledged
    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // an idle port during a refill starts a read, never a write
    p_fill_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FIRST || state_q == ST_REST) && !mem_req) |=> !(mem_req && mem_we));

    // first refill read targets the very word that missed
    p_crit_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && mem_req && !mem_we) |->
        (mem_addr[BYTE_OFF +: WORD_W] == cpu_addr[BYTE_OFF +: WORD_W] &&
         mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

    // no store to the refilled block may still be queued once its read runs
    p_no_stale_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST) |-> !blk_match);

    // the line being streamed in is closed to the processor
    p_fill_line_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REST && cpu_req && cpu_addr[OFF_W +: IDX_W] == fill_idx_q) |-> cpu_stall);

endmodule

bind wt_dm_cache wt_dm_cache_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_OFF(BYTE_OFF), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .state_q(state_q), .fill_idx_q(fill_idx_q), .blk_match(blk_match)
);

// File: tb/wt_dm_cache_test.sv
`timescale 1ns/100ps
module wt_dm_cache_test;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    wt_dm_cache uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] wmem [logic [31:0]];
    logic [31:0] lg_addr [$];
    logic        lg_we   [$];
    logic [31:0] lg_data [$];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h3C96, ~a[31:16]};
    endfunction

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (wmem.exists(a)) return wmem[a];
        return pat(a);
    endfunction

    // latency-counting memory responder
    int lat_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat_cnt == LAT - 1) begin
                    lat_cnt   <= 0;
                    mem_ack   <= 1'b1;
                    mem_rdata <= memval(mem_addr);
                    if (mem_we) wmem[mem_addr] = mem_wdata;
                    lg_addr.push_back(mem_addr);
                    lg_we.push_back(mem_we);
                    lg_data.push_back(mem_wdata);
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; holds the request until accepted
    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc, output int logn);
        cyc = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1.5;
            cyc++;
            if (!cpu_stall) begin
                rd   = cpu_rdata;
                logn = lg_addr.size();
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(60000 * 5);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, a, a2, x;
        int cyc, logn, base;
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        #1;
        chk(!cpu_stall && !mem_req, "R2 reset idle", {30'd0, cpu_stall, mem_req}, 32'd0);
        idle(1);

        // R2, R4, R5: cold miss, critical word first, early restart
        a = 32'h1000_0048;
        base = lg_addr.size();
        access(1'b0, a, '0, rd, cyc, logn);
        chk(cyc > 1, "R2 cold read misses", cyc, 2);
        chk(rd == pat(a), "R5 requested word data", rd, pat(a));
        chk(logn == base + 1, "R5 released after first word only", logn - base, 1);
        idle(30);
        chk(lg_addr.size() == base + 4, "R4 four refill reads", lg_addr.size() - base, 4);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] e;
            e = {a[31:4], 2'((2 + k) % 4), 2'b00};
            chk(lg_addr[base + k] == e && !lg_we[base + k], "R4 wrap order", lg_addr[base + k], e);
        end

        // R6: whole line hits
        for (int w = 0; w < 4; w++) begin
            a2 = {a[31:4], 2'(w), 2'b00};
            access(1'b0, a2, '0, rd, cyc, logn);
            chk(cyc == 1, "R6 line hit", cyc, 1);
            chk(rd == pat(a2), "R6 line data", rd, pat(a2));
        end

        // R1: fill every index, then sweep all words as hits (R3)
        for (int i = 0; i < 64; i++) begin
            a2 = 32'h0123_4000 | (i << 4) | ((i % 4) << 2);
            access(1'b0, a2, '0, rd, cyc, logn);
            chk(rd == pat(a2), "R1 index fill data", rd, pat(a2));
        end
        idle(30);
        for (int i = 0; i < 64; i++) begin
            for (int w = 0; w < 4; w++) begin
                a2 = 32'h0123_4000 | (i << 4) | (w << 2);
                access(1'b0, a2, '0, rd, cyc, logn);
                chk(cyc == 1 && rd == pat(a2), "R3 hit sweep", rd, pat(a2));
            end
        end

        // R1: tag alias on the same index
        access(1'b0, 32'h0ABC_4050, '0, rd, cyc, logn);
        chk(cyc > 1 && rd == pat(32'h0ABC_4050), "R1 alias misses", cyc, 2);
        idle(30);
        access(1'b0, 32'h0123_4050, '0, rd, cyc, logn);
        chk(cyc > 1, "R1 original evicted", cyc, 2);
        chk(rd == pat(32'h0123_4050), "R1 refetched data", rd, pat(32'h0123_4050));
        idle(30);

        // R7: store hit
        base = lg_addr.size();
        access(1'b1, 32'h0123_4060, 32'hD1D1_0001, rd, cyc, logn);
        chk(cyc == 1, "R7 store accepted", cyc, 1);
        access(1'b0, 32'h0123_4060, '0, rd, cyc, logn);
        chk(cyc == 1 && rd == 32'hD1D1_0001, "R7 cached word updated", rd, 32'hD1D1_0001);
        idle(20);
        chk(lg_addr.size() == base + 1 && lg_we[base] && lg_addr[base] == 32'h0123_4060
            && lg_data[base] == 32'hD1D1_0001, "R7 written through", lg_data[base], 32'hD1D1_0001);

        // R8: store miss does not allocate
        access(1'b1, 32'h0777_0070, 32'hD2D2_0002, rd, cyc, logn);
        idle(20);
        access(1'b0, 32'h0777_0070, '0, rd, cyc, logn);
        chk(cyc > 1, "R8 no allocation", cyc, 2);
        chk(rd == 32'hD2D2_0002, "R8 data from memory", rd, 32'hD2D2_0002);
        idle(30);

        // R10: read miss right behind a buffered store to the same block
        base = lg_addr.size();
        access(1'b1, 32'h0888_0080, 32'hD3D3_0003, rd, cyc, logn);
        access(1'b0, 32'h0888_0080, '0, rd, cyc, logn);
        chk(rd == 32'hD3D3_0003, "R10 refill sees store", rd, 32'hD3D3_0003);
        chk(lg_we[base] && !lg_we[base + 1], "R10 write before refill", {31'd0, lg_we[base + 1]}, 32'd0);
        idle(30);

        // R9: buffer depth, fifth back-to-back store stalls
        base = lg_addr.size();
        for (int k = 0; k < 5; k++) begin
            access(1'b1, 32'h0999_0000 + k * 16, 32'hB000_0000 + k, rd, cyc, logn);
            if (k < 4) chk(cyc == 1, "R9 store while room", cyc, 1);
            else       chk(cyc > 1, "R9 stall when full", cyc, 2);
        end
        idle(40);
        for (int k = 0; k < 5; k++) begin
            chk(lg_we[base + k] && lg_addr[base + k] == 32'h0999_0000 + k * 16
                && lg_data[base + k] == 32'hB000_0000 + k, "R7 store order", lg_data[base + k],
                32'hB000_0000 + k);
        end

        // R11, R12: traffic during the refill tail
        base = lg_addr.size();
        x = 32'h0AAA_0094;
        access(1'b0, x, '0, rd, cyc, logn);
        chk(rd == pat(x), "R5 early word", rd, pat(x));
        access(1'b1, 32'h0123_4040, 32'hC4C4_0004, rd, cyc, logn);
        chk(cyc == 1, "R12 store hit other line", cyc, 1);
        access(1'b1, 32'h0BBB_00A0, 32'hC5C5_0005, rd, cyc, logn);
        chk(cyc == 1, "R12 store miss other line", cyc, 1);
        access(1'b0, 32'h0123_4030, '0, rd, cyc, logn);
        chk(cyc == 1 && rd == pat(32'h0123_4030), "R12 read hit other line", cyc, 1);
        access(1'b0, 32'h0AAA_0098, '0, rd, cyc, logn);
        chk(cyc > 1, "R12 refilling line stalls", cyc, 2);
        chk(rd == pat(32'h0AAA_0098), "R12 refilling line data", rd, pat(32'h0AAA_0098));
        idle(40);
        chk(lg_addr.size() == base + 6, "R11 transaction count", lg_addr.size() - base, 6);
        for (int k = 0; k < 6; k++) begin
            chk(lg_we[base + k] == (k >= 4), "R11 refill before writes",
                {31'd0, lg_we[base + k]}, {31'd0, k >= 4});
        end
        access(1'b0, 32'h0123_4040, '0, rd, cyc, logn);
        chk(cyc == 1 && rd == 32'hC4C4_0004, "R7 hit store kept", rd, 32'hC4C4_0004);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule